// File: doc/BRIEF.md
# Operand Address and Auxiliary Pointer Unit

This unit produces the 8-bit data-memory address for each operand access of a small word-oriented signal processor. It also owns the two 16-bit auxiliary registers and the one-bit pointer that selects between them. An access uses one of two address forms. In direct form, a one-bit page is placed above a 7-bit field taken from the instruction. In indirect form, the low byte of the selected auxiliary register is used, and the register may then step up or down and the pointer may be reloaded.

The same register file serves three more operations. The count-down loop branch reports whether the selected register's 9-bit count is nonzero and decrements that count in the same cycle. The load-constant operation writes a zero-extended 8-bit immediate into one register. The word-load operation writes a full 16-bit value into one register. Every operation is presented as a single strobed cycle. Address and branch outputs are combinational from the current state, and register updates take effect at the next rising clock edge.

The pointer behaves as a two-state machine, with states ARP_0 (register 0 selected) and ARP_1 (register 1 selected). An indirect operand access whose reload bit (bit 3) is 0 moves it to the state named by opcode bit 0. It holds in every other case, and reset puts it in ARP_0.

Top module: `dag_unit`

## Requirements
- R1: While `rst_n` is low, AR0, AR1 and the pointer are cleared to 0. The pointer starting state is ARP_0.
- R2: The `op_kind` encodings are 0 operand access, 1 status store, 2 loop branch, 3 load constant into AR0, 4 load constant into AR1, 5 word load into AR0 and 6 word load into AR1. For kind 0 with opcode bit 7 = 0 (direct), `data_addr` = {`page_bit`, opcode bits 6:0}.
- R3: For kinds 0 and 1 with opcode bit 7 = 1 (indirect), `data_addr` is bits 7:0 of the register the pointer selects, as it stands before this cycle's update.
- R4: In indirect form (kinds 0 and 1), opcode bit 5 alone increments the selected register after the access and bit 4 alone decrements it. With both bits or neither set, the register is unchanged. Direct form changes no register.
- R5: Every step (R4, R8) changes only bits 8:0 of a register and wraps within them (0x1FF+1 gives 0x000, 0x000-1 gives 0x1FF). Bits 15:9 keep their value.
- R6: For kind 0 in indirect form with opcode bit 3 = 0, the pointer is loaded from opcode bit 0 after the register update. The register that is modified is the one selected before the reload. With bit 3 = 1, the pointer holds.
- R7: A status store (kind 1) never changes the pointer. In direct form its address is 0x80 OR opcode bits 6:0, regardless of `page_bit`.
- R8: For kind 2, `loop_taken` is 1 in the same cycle exactly when bits 8:0 of the selected register are nonzero. That count is decremented per R5 whether or not the branch is taken.
- R9: Kinds 3 and 4 write {8'h00, `op_byte`} into AR0 or AR1. Kinds 5 and 6 write `ld_word` into AR0 or AR1. None of these kinds changes the pointer.
- R10: When `op_valid` is 0, or the kind is 7, no register or pointer changes, and `data_addr` and `loop_taken` are 0. Kinds 2 to 6 also drive `data_addr` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe for this cycle |
| op_kind | input | 3 | Operation kind (encoding in R2) |
| op_byte | input | 8 | Low byte of the instruction |
| page_bit | input | 1 | Current data page bit |
| ld_word | input | 16 | Value for the word-load kinds |
| data_addr | output | 8 | Operand data address |
| loop_taken | output | 1 | Loop branch condition |
| ar0_q | output | 16 | Auxiliary register 0 |
| ar1_q | output | 16 | Auxiliary register 1 |
| arp_q | output | 1 | Auxiliary register pointer |

## Verification
Within a single indirect operand access, the register post-step and the pointer reload fall in the same cycle. The stepped register must be the one selected before the reload, and the new pointer must follow bit 0. This is provoked with pointer value 1 and an opcode that both increments and reloads to 0, and the bench then compares both registers and the pointer after the edge. A status store in indirect form likewise steps a register while holding the pointer, and that case is judged in the same way. A behavioural model, compared every clock, then covers long random mixes of all kinds, including runs that cross the 9-bit wrap.

// File: rtl/dag_pkg.sv
package dag_pkg;
    localparam int AR_W   = 16;
    localparam int CNT_W  = 9;
    localparam int ADDR_W = 8;
    localparam int NUM_AR = 2;
    localparam int ARP_W  = 1;

    typedef enum logic [2:0] {
        K_ACCESS  = 3'd0,
        K_STSTORE = 3'd1,
        K_LOOP    = 3'd2,
        K_LDK0    = 3'd3,
        K_LDK1    = 3'd4,
        K_LDW0    = 3'd5,
        K_LDW1    = 3'd6,
        K_IDLE    = 3'd7
    } dag_kind_e;

    typedef enum logic [ARP_W-1:0] {
        ARP_0 = 1'b0,
        ARP_1 = 1'b1
    } arp_state_e;
endpackage

// File: rtl/dag_addr_sel.sv
module dag_addr_sel #(
    parameter int ADDR_W = 8
) (
    input  logic              active,
    input  logic              is_status,
    input  logic [7:0]        op_byte,
    input  logic              page_bit,
    input  logic [ADDR_W-1:0] ind_src,
    output logic [ADDR_W-1:0] addr
);
    localparam int LOW_W = ADDR_W - 1;

    logic hi_bit;

    always_comb begin
        hi_bit = is_status ? 1'b1 : page_bit;
        if (!active)
            addr = '0;
        else if (op_byte[7])
            addr = ind_src;
        else
            addr = {hi_bit, op_byte[LOW_W-1:0]};
    end
endmodule

// File: rtl/dag_step.sv
module dag_step #(
    parameter int AR_W  = 16,
    parameter int CNT_W = 9
) (
    input  logic [AR_W-1:0] cur,
    input  logic            up,
    input  logic            down,
    output logic [AR_W-1:0] nxt,
    output logic            nonzero
);
    logic [CNT_W-1:0] cnt;

    always_comb begin
        cnt = cur[CNT_W-1:0];
        if (up && !down)
            cnt = cur[CNT_W-1:0] + CNT_W'(1);
        else if (down && !up)
            cnt = cur[CNT_W-1:0] - CNT_W'(1);
        nxt     = {cur[AR_W-1:CNT_W], cnt};
        nonzero = |cur[CNT_W-1:0];
    end
endmodule

// File: rtl/dag_unit.sv
module dag_unit
    import dag_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        op_valid,
    input  logic [2:0]  op_kind,
    input  logic [7:0]  op_byte,
    input  logic        page_bit,
    input  logic [15:0] ld_word,
    output logic [7:0]  data_addr,
    output logic        loop_taken,
    output logic [15:0] ar0_q,
    output logic [15:0] ar1_q,
    output logic        arp_q
);
    logic [AR_W-1:0] ar_q   [NUM_AR];
    logic [AR_W-1:0] ar_d   [NUM_AR];
    arp_state_e      arp_st, arp_nx;

    logic              mod_en, step_up, step_dn, arp_reload;
    logic              is_status, addr_act, loop_op;
    logic [NUM_AR-1:0] ldk_sel, ldw_sel;
    logic [AR_W-1:0]   sel_ar, stepped;
    logic              sel_nz;
    dag_kind_e         kind;

    assign kind   = dag_kind_e'(op_kind);
    assign sel_ar = ar_q[arp_st];

    // decode of the strobed operation
    always_comb begin
        mod_en     = 1'b0;
        step_up    = 1'b0;
        step_dn    = 1'b0;
        arp_reload = 1'b0;
        is_status  = 1'b0;
        addr_act   = 1'b0;
        loop_op    = 1'b0;
        ldk_sel    = '0;
        ldw_sel    = '0;
        if (op_valid) begin
            unique case (kind)
                K_ACCESS: begin
                    addr_act = 1'b1;
                    if (op_byte[7]) begin
                        mod_en     = 1'b1;
                        step_up    = op_byte[5];
                        step_dn    = op_byte[4];
                        arp_reload = !op_byte[3];
                    end
                end
                K_STSTORE: begin
                    addr_act  = 1'b1;
                    is_status = 1'b1;
                    if (op_byte[7]) begin
                        mod_en  = 1'b1;
                        step_up = op_byte[5];
                        step_dn = op_byte[4];
                    end
                end
                K_LOOP: begin
                    mod_en  = 1'b1;
                    step_dn = 1'b1;
                    loop_op = 1'b1;
                end
                K_LDK0:  ldk_sel[0] = 1'b1;
                K_LDK1:  ldk_sel[1] = 1'b1;
                K_LDW0:  ldw_sel[0] = 1'b1;
                K_LDW1:  ldw_sel[1] = 1'b1;
                default: ;
            endcase
        end
    end

    dag_addr_sel #(.ADDR_W(ADDR_W)) u_addr (
        .active    (addr_act),
        .is_status (is_status),
        .op_byte   (op_byte),
        .page_bit  (page_bit),
        .ind_src   (sel_ar[ADDR_W-1:0]),
        .addr      (data_addr)
    );

    dag_step #(.AR_W(AR_W), .CNT_W(CNT_W)) u_step (
        .cur     (sel_ar),
        .up      (step_up),
        .down    (step_dn),
        .nxt     (stepped),
        .nonzero (sel_nz)
    );

    assign loop_taken = loop_op && sel_nz;

    // next value of each auxiliary register
    for (genvar gi = 0; gi < NUM_AR; gi++) begin : g_ar
        always_comb begin
            if (ldw_sel[gi])
                ar_d[gi] = ld_word;
            else if (ldk_sel[gi])
                ar_d[gi] = {{(AR_W-8){1'b0}}, op_byte};
            else if (mod_en && (arp_st == arp_state_e'(gi)))
                ar_d[gi] = stepped;
            else
                ar_d[gi] = ar_q[gi];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ar_q[gi] <= '0;
            else
                ar_q[gi] <= ar_d[gi];
        end
    end

    // pointer state transitions
    always_comb begin
        arp_nx = arp_st;
        unique case (arp_st)
            ARP_0: if (arp_reload && op_byte[0])  arp_nx = ARP_1;
            ARP_1: if (arp_reload && !op_byte[0]) arp_nx = ARP_0;
            default: arp_nx = ARP_0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            arp_st <= ARP_0;
        else
            arp_st <= arp_nx;
    end

    assign ar0_q = ar_q[0];
    assign ar1_q = ar_q[1];
    assign arp_q = arp_st;
endmodule

// File: rtl/dag_unit_chk.sv
module dag_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic [2:0]  op_kind,
    input logic [7:0]  op_byte,
    input logic [7:0]  data_addr,
    input logic        loop_taken,
    input logic [15:0] ar0_q,
    input logic [15:0] ar1_q,
    input logic        arp_q
);
    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (ar0_q == 16'h0 && ar1_q == 16'h0 && arp_q == 1'b0));

    // R10
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(ar0_q) && $stable(ar1_q) && $stable(arp_q)));

    // R7
    a_r7_status_page1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 3'd1 && !op_byte[7]) |-> data_addr[7]);

    // R7
    a_r7_status_arp: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 3'd1) |=> $stable(arp_q));

    // R5
    a_r5_upper_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind <= 3'd2) |=>
            (ar0_q[15:9] == $past(ar0_q[15:9]) && ar1_q[15:9] == $past(ar1_q[15:9])));

    // R8
    a_r8_taken_qual: assert property (@(posedge clk) disable iff (!rst_n)
        loop_taken |-> (op_valid && op_kind == 3'd2));

    // R8
    a_r8_loop_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 3'd2 && !arp_q) |=>
            ar0_q[8:0] == $past(ar0_q[8:0]) - 9'd1);
endmodule

bind dag_unit dag_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_kind    (op_kind),
    .op_byte    (op_byte),
    .data_addr  (data_addr),
    .loop_taken (loop_taken),
    .ar0_q      (ar0_q),
    .ar1_q      (ar1_q),
    .arp_q      (arp_q)
);

// File: tb/tb_dag_unit.sv
module tb_dag_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_kind = 3'd7;
    logic [7:0]  op_byte = 8'h00;
    logic        page_bit = 1'b0;
    logic [15:0] ld_word = 16'h0;
    logic [7:0]  data_addr;
    logic        loop_taken;
    logic [15:0] ar0_q, ar1_q;
    logic        arp_q;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [15:0] m_ar [2];
    logic        m_arp;
    string       last_tag = "R1";

    dag_unit dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .op_byte(op_byte), .page_bit(page_bit), .ld_word(ld_word),
        .data_addr(data_addr), .loop_taken(loop_taken),
        .ar0_q(ar0_q), .ar1_q(ar1_q), .arp_q(arp_q)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    function automatic logic [15:0] step9(input logic [15:0] v, input bit up, input bit dn);
        logic [8:0] c;
        c = v[8:0];
        if (up && !dn) c = c + 9'd1;
        else if (dn && !up) c = c - 9'd1;
        return {v[15:9], c};
    endfunction

    // one strobed cycle: check state, drive, check combinational outputs, advance model
    task automatic op(input string tag, input bit v, input logic [2:0] k,
                      input logic [7:0] b, input bit pg, input logic [15:0] w);
        logic [7:0]  e_addr;
        bit          e_tk;
        logic [15:0] sel;
        @(negedge clk);
        chk(last_tag, "ar0", {16'h0, ar0_q}, {16'h0, m_ar[0]});
        chk(last_tag, "ar1", {16'h0, ar1_q}, {16'h0, m_ar[1]});
        chk(last_tag, "arp", {31'h0, arp_q}, {31'h0, m_arp});
        op_valid = v; op_kind = k; op_byte = b; page_bit = pg; ld_word = w;
        #1;
        sel = m_ar[m_arp];
        e_addr = 8'h00;
        e_tk = 1'b0;
        if (v && (k == 3'd0 || k == 3'd1)) begin
            if (b[7]) e_addr = sel[7:0];
            else e_addr = {(k == 3'd1) ? 1'b1 : pg, b[6:0]};
        end
        if (v && k == 3'd2) e_tk = (sel[8:0] != 9'd0);
        chk(tag, "data_addr", {24'h0, data_addr}, {24'h0, e_addr});
        chk(tag, "loop_taken", {31'h0, loop_taken}, {31'h0, e_tk});
        if (v) begin
            case (k)
                3'd0, 3'd1: if (b[7]) begin
                    m_ar[m_arp] = step9(sel, b[5], b[4]);
                    if (k == 3'd0 && !b[3]) m_arp = b[0];
                end
                3'd2: m_ar[m_arp] = step9(sel, 1'b0, 1'b1);
                3'd3: m_ar[0] = {8'h00, b};
                3'd4: m_ar[1] = {8'h00, b};
                3'd5: m_ar[0] = w;
                3'd6: m_ar[1] = w;
                default: ;
            endcase
        end
        last_tag = tag;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        m_ar[0] = 16'h0; m_ar[1] = 16'h0; m_arp = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "ar0 in reset", {16'h0, ar0_q}, 32'h0);
        chk("R1", "arp in reset", {31'h0, arp_q}, 32'h0);
        rst_n = 1'b1;
        op("R1", 1'b0, 3'd7, 8'h00, 1'b0, 16'h0);
        // R9 constant and word loads
        op("R9", 1'b1, 3'd3, 8'h05, 1'b0, 16'h0);
        op("R9", 1'b1, 3'd4, 8'hFF, 1'b0, 16'hFFFF);
        op("R9", 1'b1, 3'd5, 8'h00, 1'b0, 16'hA5FF);
        // R5 wrap up then down, upper bits kept; R3 address before modify
        op("R5", 1'b1, 3'd0, 8'hA8, 1'b0, 16'h0);
        op("R5", 1'b1, 3'd0, 8'h98, 1'b0, 16'h0);
        op("R3", 1'b1, 3'd0, 8'h98, 1'b1, 16'h0);
        // R4 both bits / neither bit leave the register
        op("R4", 1'b1, 3'd0, 8'hB8, 1'b0, 16'h0);
        op("R4", 1'b1, 3'd0, 8'h88, 1'b0, 16'h0);
        // R2 direct access on both pages, no register change
        op("R2", 1'b1, 3'd0, 8'h45, 1'b1, 16'h0);
        op("R2", 1'b1, 3'd0, 8'h7F, 1'b0, 16'h0);
        op("R4", 1'b1, 3'd0, 8'h31, 1'b0, 16'h0);
        // R6 reload to 1, then step the old selection while reloading to 0
        op("R6", 1'b1, 3'd0, 8'h81, 1'b0, 16'h0);
        op("R6", 1'b1, 3'd0, 8'hA0, 1'b0, 16'h0);
        op("R6", 1'b1, 3'd0, 8'h89, 1'b0, 16'h0);
        // R7 status store direct ignores page, indirect steps but keeps pointer
        op("R7", 1'b1, 3'd1, 8'h12, 1'b0, 16'h0);
        op("R7", 1'b1, 3'd0, 8'h81, 1'b0, 16'h0);
        op("R7", 1'b1, 3'd1, 8'hA0, 1'b0, 16'h0);
        op("R7", 1'b1, 3'd1, 8'h96, 1'b1, 16'h0);
        // R8 loop branch through zero
        op("R8", 1'b1, 3'd4, 8'h02, 1'b0, 16'h0);
        op("R8", 1'b1, 3'd2, 8'h00, 1'b0, 16'h0);
        op("R8", 1'b1, 3'd2, 8'h00, 1'b0, 16'h0);
        op("R8", 1'b1, 3'd2, 8'h00, 1'b0, 16'h0);
        op("R8", 1'b1, 3'd2, 8'h00, 1'b0, 16'h0);
        op("R8", 1'b1, 3'd6, 8'h00, 1'b0, 16'hFE00);
        op("R8", 1'b1, 3'd2, 8'h00, 1'b0, 16'h0);
        // R10 no strobe or unused kind
        op("R10", 1'b0, 3'd0, 8'hA1, 1'b1, 16'h1234);
        op("R10", 1'b0, 3'd3, 8'h77, 1'b0, 16'h1234);
        op("R10", 1'b1, 3'd7, 8'hA0, 1'b1, 16'h1234);
        op("R10", 1'b1, 3'd5, 8'hFF, 1'b0, 16'h1234);
        // random mix
        for (int i = 0; i < 800; i++) begin
            logic [2:0] k;
            k = 3'($urandom_range(0, 7));
            if (k >= 3'd3 && ($urandom_range(0, 3) != 0)) k = 3'($urandom_range(0, 2));
            op("RND", ($urandom_range(0, 9) != 0), k, 8'($urandom),
               1'($urandom), 16'($urandom));
        end
        op("RND", 1'b0, 3'd7, 8'h00, 1'b0, 16'h0);
        finish_run();
    end
endmodule